// File: doc/BRIEF.md
# Memory-Mapped Vectored Interrupt Controller

This block gathers a set of interrupt lines, up to 32, and merges them into a single request to a processor. Each line is fixed at build time as either edge-sensitive, where a rising transition is latched, or level-sensitive, where the line sets its latched bit on every clock it is high. Latched bits are masked by a per-line enable and then combined into one request output. That output is also gated by two global enable bits.

Software reaches the block over a plain 32-bit register bus. The bus has a byte address, write data, a write strobe, a read strobe and combinational read data. Through it, software can:

- read the latched status and the masked pending set;
- replace the enable mask outright, or set or clear individual enable bits through write-one aliases;
- acknowledge latched bits;
- read a vector register that names the lowest-numbered pending line.

The vector register returns all-ones when nothing is pending.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, the status, pending, enable, vector and master registers are cleared. In particular, status, pending, enable and master read 0, and the vector reads 0xFFFFFFFF. `irq_req` is low. Word offsets: 0x00 status, 0x04 pending, 0x08 enable, 0x0C acknowledge, 0x10 set-enable, 0x14 clear-enable, 0x18 vector, 0x1C master.
- R2: An edge-mode line (its bit set to one in `EDGE_MASK`) sets its status bit on the clock after a rising edge. Acknowledging it while the line stays high leaves the bit clear until the next rising edge.
- R3: A level-mode line (its bit zero in `EDGE_MASK`) sets its status bit on each clock it is high. An acknowledge clears the bit on that clock. The bit sets again on the following clock if the line is still high.
- R4: Writing to the acknowledge offset clears exactly the status bits written as one. Writing 0xFFFFFFFF clears them all.
- R5: A write to the enable offset replaces the mask. Set-enable sets only the bits written as one, and clear-enable clears only those bits; every other enable bit is kept.
- R6: The pending register reads as status AND enable. Masking an input leaves its status bit latched.
- R7: The vector register returns the index of the lowest-numbered pending bit, or 0xFFFFFFFF when no bit is pending.
- R8: `irq_req` is high exactly when some pending bit is set and master bits 0 (global enable) and 1 (hardware enable) are both one.
- R9: The master register reads back the last written bit 0. Bit 1, once written as one, stays one until reset.
- R10: On an edge-mode line, a rising edge arriving in the same clock as an acknowledge of that line leaves its status bit set.
- R11: Writes to the status, pending and vector offsets change nothing. Reads of the acknowledge, set-enable and clear-enable offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | N_IN | Interrupt lines, synchronous to clk |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_re | input | 1 | Read strobe; read data is zero when low |
| bus_rdata | output | 32 | Read data, combinational from address and registers |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
An acknowledge write can land on the same clock as a new capture event for the same line, and the outcome depends on the mode. The bench drives a fresh rising edge on an edge-mode line in the very cycle the acknowledge is strobed, and expects the status bit to survive. It also acknowledges a level-mode line whose input stays high, and samples status in the half-cycle right after the acknowledge edge, where the bit must read clear, and again one clock later, where it must read set again. A sweep over every input pattern of an 8-line build with mixed modes checks pending, vector and request against values computed in the bench.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned BUS_W = 32;

  typedef enum logic [2:0] {
    SEL_STAT = 3'd0,
    SEL_PEND = 3'd1,
    SEL_ENAB = 3'd2,
    SEL_ACK  = 3'd3,
    SEL_SETE = 3'd4,
    SEL_CLRE = 3'd5,
    SEL_VEC  = 3'd6,
    SEL_MCTL = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int unsigned N_IN      = 32,
  parameter logic [31:0] EDGE_MASK = 32'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] irq_in,
  input  logic [N_IN-1:0] ack,
  output logic [N_IN-1:0] status
);
  logic [N_IN-1:0] line_q;
  logic [N_IN-1:0] stat_q;
  logic [N_IN-1:0] stat_d;
  logic [N_IN-1:0] rise;

  assign rise = irq_in & ~line_q;

  for (genvar i = 0; i < N_IN; i++) begin : g_bit
    if (EDGE_MASK[i]) begin : g_edge
      // a new edge wins over a simultaneous acknowledge
      assign stat_d[i] = rise[i] | (stat_q[i] & ~ack[i]);

      assert_edge_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack[i] && !rise[i]) |=> !stat_q[i]);
      assert_edge_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rise[i] |=> stat_q[i]);
    end else begin : g_level
      // acknowledge wins; a high line re-latches one clock later
      assign stat_d[i] = ~ack[i] & (stat_q[i] | irq_in[i]);

      assert_level_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ack[i] |=> !stat_q[i]);
      assert_level_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_in[i] && !ack[i]) |=> stat_q[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      stat_q <= '0;
    end else begin
      line_q <= irq_in;
      stat_q <= stat_d;
    end
  end

  assign status = stat_q;
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs #(
  parameter int unsigned N_IN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_enab,
  input  logic            we_sete,
  input  logic            we_clre,
  input  logic            we_mctl,
  input  logic [N_IN-1:0] wmask,
  input  logic [1:0]      wmctl,
  output logic [N_IN-1:0] enab,
  output logic            glb_en,
  output logic            hw_en
);
  logic [N_IN-1:0] enab_q, enab_d;
  logic            glb_q, glb_d;
  logic            hw_q, hw_d;
  logic            enab_ce;

  assign enab_ce = we_enab | we_sete | we_clre;

  always_comb begin
    enab_d = enab_q;
    if (we_enab)      enab_d = wmask;
    else if (we_sete) enab_d = enab_q | wmask;
    else if (we_clre) enab_d = enab_q & ~wmask;
  end

  always_comb begin
    glb_d = wmctl[0];
    hw_d  = hw_q | wmctl[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enab_q <= '0;
      glb_q  <= 1'b0;
      hw_q   <= 1'b0;
    end else begin
      if (enab_ce) enab_q <= enab_d;
      if (we_mctl) begin
        glb_q <= glb_d;
        hw_q  <= hw_d;
      end
    end
  end

  assign enab   = enab_q;
  assign glb_en = glb_q;
  assign hw_en  = hw_q;

  assert_hw_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hw_q |=> hw_q);
  assert_set_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we_sete |=> ((enab_q & $past(wmask)) == $past(wmask)));
  assert_clr_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we_clre |=> ((enab_q & $past(wmask)) == '0));
endmodule

// File: rtl/irq_lowest_enc.sv
module irq_lowest_enc #(
  parameter int unsigned N_IN  = 32,
  localparam int unsigned IDX_W = $clog2(N_IN)
) (
  input  logic [N_IN-1:0]  pend,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = |pend;
    idx   = '0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (pend[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int unsigned N_IN      = 32,
  parameter logic [31:0] EDGE_MASK = 32'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  irq_in,
  input  logic [4:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  input  logic             bus_we,
  input  logic             bus_re,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             irq_req
);
  localparam int unsigned IDX_W = $clog2(N_IN);

  logic [1:0]       rst_sync;
  logic             rst_ns;
  reg_sel_e         sel;
  logic [N_IN-1:0]  status, enab, pending, ack;
  logic             glb_en, hw_en, found;
  logic [IDX_W-1:0] idx;
  logic [BUS_W-1:0] rd_word;
  logic [1:0]       unused_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  assign sel         = reg_sel_e'(bus_addr[4:2]);
  assign unused_addr = bus_addr[1:0];
  assign ack         = (bus_we && sel == SEL_ACK) ? bus_wdata[N_IN-1:0] : '0;

  irq_capture #(.N_IN(N_IN), .EDGE_MASK(EDGE_MASK)) u_capture (
    .clk    (clk),
    .rst_n  (rst_ns),
    .irq_in (irq_in),
    .ack    (ack),
    .status (status)
  );

  irq_ctl_regs #(.N_IN(N_IN)) u_regs (
    .clk     (clk),
    .rst_n   (rst_ns),
    .we_enab (bus_we && sel == SEL_ENAB),
    .we_sete (bus_we && sel == SEL_SETE),
    .we_clre (bus_we && sel == SEL_CLRE),
    .we_mctl (bus_we && sel == SEL_MCTL),
    .wmask   (bus_wdata[N_IN-1:0]),
    .wmctl   (bus_wdata[1:0]),
    .enab    (enab),
    .glb_en  (glb_en),
    .hw_en   (hw_en)
  );

  assign pending = status & enab;

  irq_lowest_enc #(.N_IN(N_IN)) u_enc (
    .pend  (pending),
    .found (found),
    .idx   (idx)
  );

  assign irq_req = found & glb_en & hw_en;

  always_comb begin
    rd_word = '0;
    case (sel)
      SEL_STAT: rd_word[N_IN-1:0] = status;
      SEL_PEND: rd_word[N_IN-1:0] = pending;
      SEL_ENAB: rd_word[N_IN-1:0] = enab;
      SEL_VEC: begin
        if (found) rd_word[IDX_W-1:0] = idx;
        else       rd_word = '1;
      end
      SEL_MCTL: rd_word[1:0] = {hw_en, glb_en};
      default:  rd_word = '0;
    endcase
  end

  assign bus_rdata = bus_re ? rd_word : '0;

  assert_vec_hit_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    found |-> pending[idx]);
  assert_vec_lowest_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    found |-> ((pending & ((N_IN'(1) << idx) - N_IN'(1))) == '0));
  assert_req_src_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    irq_req |-> (|status));
endmodule

// File: tb/irq_vec_ctrl_bench.sv
module irq_vec_ctrl_bench;
  localparam int N = 8;
  localparam logic [31:0] EM = 32'h0000_00F0;
  localparam logic [4:0] A_STAT = 5'h00, A_PEND = 5'h04, A_ENAB = 5'h08,
    A_ACK = 5'h0C, A_SETE = 5'h10, A_CLRE = 5'h14, A_VEC = 5'h18, A_MCTL = 5'h1C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [N-1:0] irq_in;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we, bus_re;
  logic [31:0] bus_rdata;
  logic        irq_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  irq_vec_ctrl #(.N_IN(N), .EDGE_MASK(EM)) u_irq_vec_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .irq_req(irq_req)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 v = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [31:0] v);
    bus_addr = a; bus_re = 1'b1;
    #1 v = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] p);
    @(negedge clk); irq_in = p;
    @(negedge clk); irq_in = '0;
  endtask

  function automatic logic [31:0] low_idx(input logic [N-1:0] p);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int i = N - 1; i >= 0; i--) if (p[i]) r = 32'(i);
    return r;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [N-1:0] e;
    rst_n = 1'b0; irq_in = '0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(A_STAT, v); chk("R1 status", v, 0);
    rd(A_PEND, v); chk("R1 pending", v, 0);
    rd(A_ENAB, v); chk("R1 enable", v, 0);
    rd(A_VEC, v);  chk("R1 vector", v, 32'hFFFF_FFFF);
    rd(A_MCTL, v); chk("R1 master", v, 0);
    chk("R1 irq_req", {31'b0, irq_req}, 0);

    wr(A_MCTL, 32'h3);
    rd(A_MCTL, v); chk("R9 master readback", v, 3);

    // sweep every input pattern: R6 R7 R8 R4
    for (int p = 0; p < 256; p++) begin
      e = N'((p * 37 + 11) & 8'hFF);
      pulse(N'(p));
      rd(A_STAT, v); chk("R2/R3 sweep status", v, 32'(p));
      wr(A_ENAB, {24'b0, e});
      rd(A_PEND, v); chk("R6 sweep pending", v, 32'(N'(p) & e));
      rd(A_VEC, v);  chk("R7 sweep vector", v, low_idx(N'(p) & e));
      chk("R8 sweep irq_req", {31'b0, irq_req}, {31'b0, |(N'(p) & e)});
      wr(A_ACK, 32'hFF);
      rd(A_STAT, v); chk("R4 sweep ack all", v, 0);
    end

    wr(A_ENAB, 32'hFF);
    // R2 edge held high
    @(negedge clk); irq_in[5] = 1'b1;
    rd(A_STAT, v); chk("R2 edge latched", v, 32'h20);
    wr(A_ACK, 32'h20);
    rd(A_STAT, v); chk("R2 edge ack while high", v, 0);
    repeat (2) @(negedge clk);
    rd(A_STAT, v); chk("R2 no relatch while high", v, 0);
    @(negedge clk); irq_in[5] = 1'b0;
    @(negedge clk); irq_in[5] = 1'b1;
    rd(A_STAT, v); chk("R2 new edge", v, 32'h20);
    irq_in[5] = 1'b0;
    wr(A_ACK, 32'hFF);

    // R3 level re-latch
    @(negedge clk); irq_in[2] = 1'b1;
    rd(A_STAT, v); chk("R3 level set", v, 32'h04);
    wr(A_ACK, 32'h04);
    peek(A_STAT, v); chk("R3 cleared on ack clock", v, 0);
    rd(A_STAT, v); chk("R3 relatch next clock", v, 32'h04);
    @(negedge clk); irq_in[2] = 1'b0;
    wr(A_ACK, 32'h04);
    rd(A_STAT, v); chk("R3 clear after line low", v, 0);

    // R10 edge coinciding with ack
    pulse(8'h40);
    @(negedge clk);
    bus_addr = A_ACK; bus_wdata = 32'h40; bus_we = 1'b1; irq_in[6] = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    rd(A_STAT, v); chk("R10 edge beats ack", v, 32'h40);
    wr(A_ACK, 32'h40);
    rd(A_STAT, v); chk("R10 ack without edge", v, 0);
    irq_in[6] = 1'b0;

    // R4 partial ack
    pulse(8'hB0);
    rd(A_STAT, v); chk("R4 setup", v, 32'hB0);
    wr(A_ACK, 32'h10);
    rd(A_STAT, v); chk("R4 partial ack", v, 32'hA0);
    wr(A_ACK, 32'hFFFF_FFFF);
    rd(A_STAT, v); chk("R4 ack all ones", v, 0);

    // R6 masking keeps status
    pulse(8'h30);
    wr(A_ENAB, 32'h0);
    rd(A_STAT, v); chk("R6 status kept when masked", v, 32'h30);
    rd(A_PEND, v); chk("R6 pending masked", v, 0);
    rd(A_VEC, v);  chk("R7 vector none", v, 32'hFFFF_FFFF);
    chk("R8 req masked", {31'b0, irq_req}, 0);
    wr(A_ENAB, 32'h20);
    rd(A_PEND, v); chk("R6 pending unmasked", v, 32'h20);
    rd(A_VEC, v);  chk("R7 vector single", v, 5);

    // R5 set / clear aliases
    wr(A_ENAB, 32'h0F);
    wr(A_SETE, 32'h30);
    rd(A_ENAB, v); chk("R5 set-enable", v, 32'h3F);
    wr(A_CLRE, 32'h05);
    rd(A_ENAB, v); chk("R5 clear-enable", v, 32'h3A);

    // R9 / R8 master bits
    wr(A_MCTL, 32'h0);
    rd(A_MCTL, v); chk("R9 hw bit sticky", v, 2);
    chk("R8 req with global off", {31'b0, irq_req}, 0);
    wr(A_MCTL, 32'h1);
    rd(A_MCTL, v); chk("R9 global back on", v, 3);
    chk("R8 req both on", {31'b0, irq_req}, 1);
    wr(A_MCTL, 32'h2);
    chk("R8 req global cleared", {31'b0, irq_req}, 0);

    // R11 read-only and write-only offsets
    wr(A_STAT, 32'hFF);
    rd(A_STAT, v); chk("R11 status write ignored", v, 32'h30);
    wr(A_VEC, 32'h0);
    rd(A_VEC, v);  chk("R11 vector write ignored", v, 4);
    wr(A_PEND, 32'h0);
    rd(A_PEND, v); chk("R11 pending write ignored", v, 32'h30);
    rd(A_ACK, v);  chk("R11 ack reads zero", v, 0);
    rd(A_SETE, v); chk("R11 set-enable reads zero", v, 0);
    rd(A_CLRE, v); chk("R11 clear-enable reads zero", v, 0);

    finish_run();
  end
endmodule